// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit executes the single-bit shift family of an 8/16-bit accumulator processor: shift left with zero fill, shift right with zero fill, and rotate left or right through the carry flag. Each request carries an 8-bit instruction code, a 16-bit operand, the current carry, and a width bit. The unit decodes the code into an operation and an addressing form. It computes the shifted value and the new negative, zero and carry flags. It also reports how many cycles the instruction takes on the selected processor variant.

The sequencer pulses `valid_i` together with the inputs. One clock later the registered outputs hold the answer, and `out_valid_o` marks that cycle. Fetching and writing back memory operands is left to the surrounding core.

Top module: `shift_rotate_unit`

## Requirements
- R1: Shift left (codes with bits 6:5 = 00) and shift right (bits 6:5 = 10) put a 0 into the bit position that the shift vacates.
- R2: Rotate left (bits 6:5 = 01) and rotate right (bits 6:5 = 11) put `carry_i` into the bit position that the rotation vacates.
- R3: The new carry is the bit that leaves the value: the operand MSB for a left move and the operand bit 0 for a right move.
- R4: The new N flag is the result MSB, and the new Z flag is 1 exactly when the result is zero at the active width.
- R5: The unit works on 16 bits only when `variant_i` bit 1 is set and `narrow_i` is 0. In every other case it works on bits 7:0, and result bits 15:8 are 0.
- R6: The legal codes are those with bit 7 = 0 and low nibble 6, E, or A with bit 4 = 0. The addressing code `addr_mode_o` is 0 for accumulator (low nibble A), 1 for absolute (E, bit 4 = 0), 2 for direct page (6, bit 4 = 0), 3 for absolute indexed (E, bit 4 = 1) and 4 for direct page indexed (6, bit 4 = 1).
- R7: The base cycle counts are 2 for accumulator, 6 for absolute, 5 for direct page, 7 for absolute indexed and 6 for direct page indexed.
- R8: On the 16-bit-capable variant (`variant_i` = 2), a 16-bit operation in any memory mode adds 2 cycles. Direct page and direct page indexed add 1 more cycle when `dp_low_nz_i` is 1.
- R9: On the CMOS variant (`variant_i` = 1), absolute indexed takes one cycle fewer when `page_cross_i` is 0.
- R10: A valid request with an illegal code sets `illegal_o`. The result, flags, mode and cycle outputs keep their previous values.
- R11: Outputs change one clock after a valid request, and `out_valid_o` follows `valid_i` with one cycle of delay. Synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Request strobe |
| opcode_i | input | 8 | Instruction code |
| operand_i | input | 16 | Value to shift |
| carry_i | input | 1 | Incoming carry flag |
| narrow_i | input | 1 | 1 selects 8-bit data, 0 selects 16-bit data where supported |
| variant_i | input | 2 | 0 NMOS, 1 CMOS, 2 16-bit capable |
| dp_low_nz_i | input | 1 | Low byte of the direct-page base is nonzero |
| page_cross_i | input | 1 | Indexed address crosses a page |
| out_valid_o | output | 1 | Result registers were loaded last clock |
| result_o | output | 16 | Shifted value |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| addr_mode_o | output | 3 | Addressing form code |
| cycles_o | output | 4 | Instruction cycle count |
| illegal_o | output | 1 | Code is not a shift or rotate |

## Verification
The first group of patterns uses single-bit and all-zero operands: 0x80 shifted left, 0x01 shifted right, and zero rotated with carry set. These show the difference between zero fill and carry fill, and they show which end feeds the carry out. A 16-bit operand whose upper byte is set is applied in both widths, which shows whether the upper byte is masked in 8-bit mode. Every one of the 256 codes is then swept on each variant with random operands, carries and adjustment bits. This separates legal codes from illegal ones and checks each addressing mode against each cycle-count rule. An idle cycle and an illegal request appear between real operations to show that the held outputs stay unchanged.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid_i,
  input  logic [7:0]    opcode_i,
  input  logic [DW-1:0] operand_i,
  input  logic          carry_i,
  input  logic          narrow_i,
  input  logic [1:0]    variant_i,
  input  logic          dp_low_nz_i,
  input  logic          page_cross_i,
  output logic          out_valid_o,
  output logic [DW-1:0] result_o,
  output logic          flag_n_o,
  output logic          flag_z_o,
  output logic          flag_c_o,
  output logic [2:0]    addr_mode_o,
  output logic [CW-1:0] cycles_o,
  output logic          illegal_o
);
  localparam int NW = DW / 2;

  logic [3:0] lo;
  logic       idx, go_left, rotate, legal, wide, fill, cout, n_nx, z_nx;
  logic [2:0] mode;
  logic [DW-1:0] res;
  logic [CW-1:0] cyc;

  assign lo      = opcode_i[3:0];
  assign idx     = opcode_i[4];
  assign go_left = ~opcode_i[6];
  assign rotate  = opcode_i[5];
  assign legal   = ~opcode_i[7] & ((lo == 4'h6) | (lo == 4'hE) | ((lo == 4'hA) & ~idx));
  assign wide    = variant_i[1] & ~narrow_i;
  assign fill    = rotate & carry_i;

  always_comb begin
    if (lo == 4'hA)      mode = 3'd0;
    else if (lo == 4'hE) mode = idx ? 3'd3 : 3'd1;
    else                 mode = idx ? 3'd4 : 3'd2;
  end

  always_comb begin
    res = '0;
    if (wide) begin
      res  = go_left ? {operand_i[DW-2:0], fill} : {fill, operand_i[DW-1:1]};
      cout = go_left ? operand_i[DW-1] : operand_i[0];
      n_nx = res[DW-1];
      z_nx = (res == '0);
    end else begin
      res[NW-1:0] = go_left ? {operand_i[NW-2:0], fill} : {fill, operand_i[NW-1:1]};
      cout = go_left ? operand_i[NW-1] : operand_i[0];
      n_nx = res[NW-1];
      z_nx = (res[NW-1:0] == '0);
    end
  end

  always_comb begin
    case (mode)
      3'd0:    cyc = CW'(2);
      3'd1:    cyc = CW'(6);
      3'd2:    cyc = CW'(5);
      3'd3:    cyc = CW'(7);
      default: cyc = CW'(6);
    endcase
    if (wide && mode != 3'd0) cyc = cyc + CW'(2);
    if (variant_i[1] && dp_low_nz_i && (mode == 3'd2 || mode == 3'd4)) cyc = cyc + CW'(1);
    if (variant_i == 2'd1 && mode == 3'd3 && !page_cross_i) cyc = cyc - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      flag_n_o    <= 1'b0;
      flag_z_o    <= 1'b0;
      flag_c_o    <= 1'b0;
      addr_mode_o <= '0;
      cycles_o    <= '0;
      illegal_o   <= 1'b0;
    end else begin
      out_valid_o <= valid_i;
      if (valid_i) begin
        illegal_o <= ~legal;
        if (legal) begin
          result_o    <= res;
          flag_n_o    <= n_nx;
          flag_z_o    <= z_nx;
          flag_c_o    <= cout;
          addr_mode_o <= mode;
          cycles_o    <= cyc;
        end
      end
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> out_valid_o); // R11
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !legal) |=> (illegal_o && $stable(result_o) && $stable(flag_c_o) && $stable(cycles_o))); // R10
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
    (valid_i && legal && !wide) |=> (result_o[DW-1:NW] == '0)); // R5
  AST_CYCLE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !illegal_o) |-> (cycles_o >= CW'(2) && cycles_o <= CW'(10))); // R7
  AST_MODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (valid_i && legal) |=> (addr_mode_o <= 3'd4)); // R6
endmodule

// File: tb/sim_shift_rotate_unit.sv
module sim_shift_rotate_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, valid_i = 1'b0, carry_i = 1'b0, narrow_i = 1'b1;
  logic        dp_low_nz_i = 1'b0, page_cross_i = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic [15:0] operand_i = 16'h0;
  logic [1:0]  variant_i = 2'd0;
  logic        out_valid_o, flag_n_o, flag_z_o, flag_c_o, illegal_o;
  logic [15:0] result_o;
  logic [2:0]  addr_mode_o;
  logic [3:0]  cycles_o;

  shift_rotate_unit u0 (.*);

  int checks = 0, errs = 0;
  int e_res = 0, e_n = 0, e_z = 0, e_c = 0, e_mode = 0, e_cyc = 0, e_ill = 0, e_val = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h (op=%02h var=%0d)", tag, what, act, exp, opcode_i, variant_i);
    end
  endtask

  task automatic compare();
    chk("R11", "out_valid", int'(out_valid_o), e_val);
    chk("R1",  "result", int'(result_o), e_res);
    chk("R4",  "N", int'(flag_n_o), e_n);
    chk("R4",  "Z", int'(flag_z_o), e_z);
    chk("R3",  "C", int'(flag_c_o), e_c);
    chk("R6",  "mode", int'(addr_mode_o), e_mode);
    chk("R7",  "cycles", int'(cycles_o), e_cyc);
    chk("R10", "illegal", int'(illegal_o), e_ill);
  endtask

  task automatic apply(int op, int v, int c, int nar, int vr, int dpnz, int pc, int vld);
    int hi, lo, kind, w, mask, x, r, co, mode, cyc;
    bit legal, wide;
    int base[5] = '{2, 6, 5, 7, 6};
    @(negedge clk);
    compare();
    rst = 1'b0; valid_i = vld[0]; opcode_i = op[7:0]; operand_i = v[15:0]; carry_i = c[0];
    narrow_i = nar[0]; variant_i = vr[1:0]; dp_low_nz_i = dpnz[0]; page_cross_i = pc[0];
    hi = op / 16; lo = op % 16; kind = hi / 2;
    legal = (hi < 8) && (lo == 6 || lo == 14 || (lo == 10 && hi % 2 == 0));
    mode = (lo == 10) ? 0 : (lo == 14) ? ((hi % 2) ? 3 : 1) : ((hi % 2) ? 4 : 2);
    wide = (vr >= 2) && (nar == 0);
    w = wide ? 16 : 8; mask = (1 << w) - 1; x = v & mask;
    case (kind)
      0: begin r = (x * 2) & mask; co = (x >> (w - 1)) & 1; end
      1: begin r = ((x * 2) | c) & mask; co = (x >> (w - 1)) & 1; end
      2: begin r = x / 2; co = x % 2; end
      default: begin r = (x / 2) | (c << (w - 1)); co = x % 2; end
    endcase
    cyc = base[mode];
    if (wide && mode != 0) cyc += 2;
    if (vr >= 2 && dpnz != 0 && (mode == 2 || mode == 4)) cyc += 1;
    if (vr == 1 && mode == 3 && pc == 0) cyc -= 1;
    e_val = vld;
    if (vld != 0) begin
      e_ill = legal ? 0 : 1;
      if (legal) begin
        e_res = r; e_c = co; e_z = (r == 0); e_n = (r >> (w - 1)) & 1;
        e_mode = mode; e_cyc = cyc;
      end
    end
  endtask

  task automatic reset_pulse();
    @(negedge clk);
    compare();
    rst = 1'b1; valid_i = 1'b0;
    e_res = 0; e_n = 0; e_z = 0; e_c = 0; e_mode = 0; e_cyc = 0; e_ill = 0; e_val = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    compare();                                        // R11 reset state
    apply(8'h0A, 16'h0080, 0, 1, 0, 0, 0, 1);         // R1 R3 R4: 0x80<<1 -> 0, C=1, Z=1
    apply(8'h4A, 16'h0001, 1, 1, 0, 0, 0, 1);         // R1 R3: LSR ignores carry
    apply(8'h2A, 16'h0000, 1, 1, 1, 0, 0, 1);         // R2: ROL fills with carry -> 01
    apply(8'h6A, 16'h0000, 1, 1, 1, 0, 0, 1);         // R2 R4: ROR -> 80, N=1
    apply(8'h6E, 16'h0001, 1, 0, 2, 0, 0, 1);         // R5 R8: 16-bit ROR -> 8000, C=1, 8 cycles
    apply(8'h06, 16'hFF80, 0, 1, 2, 0, 0, 1);         // R5: narrow on wide-capable part, upper byte zero
    apply(8'h06, 16'hFF80, 0, 0, 0, 0, 0, 1);         // R5: narrow_i=0 ignored on NMOS
    apply(8'h1E, 16'h00AA, 0, 1, 1, 0, 0, 1);         // R9: CMOS no crossing -> 6
    apply(8'h1E, 16'h00AA, 0, 1, 1, 0, 1, 1);         // R9: CMOS crossing -> 7
    apply(8'h1E, 16'h00AA, 0, 1, 0, 0, 0, 1);         // R9: NMOS always 7
    apply(8'h16, 16'h4000, 0, 0, 2, 1, 0, 1);         // R8: dp indexed wide + dp offset -> 9
    apply(8'h46, 16'h0003, 0, 1, 2, 1, 0, 1);         // R8: dp narrow + dp offset -> 6
    apply(8'h1A, 16'h1234, 1, 1, 0, 0, 0, 1);         // R10: illegal holds outputs
    apply(8'h3E, 16'h1234, 1, 1, 0, 0, 0, 0);         // R11: idle cycle
    apply(8'h56, 16'h0002, 0, 1, 0, 0, 0, 1);
    reset_pulse();                                    // R11 mid-run reset
    for (int vr = 0; vr < 3; vr++)
      for (int op = 0; op < 256; op++)
        apply(op, int'($urandom_range(0, 65535)), int'($urandom_range(0, 1)),
              int'($urandom_range(0, 1)), vr, int'($urandom_range(0, 1)),
              int'($urandom_range(0, 1)), 1);
    apply(0, 0, 0, 1, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end
endmodule